// File: doc/BRIEF.md
# Predicate Register and Guard Unit

This block keeps a small file of one-bit predicates for an in-order datapath and uses them to gate execution. A compare port evaluates an equality test, an inequality test, or a single-bit test of an operand. It writes the result to a first target predicate and the inverse of the result to a second target predicate. A guard port takes the qualifying predicate and the class of each issued instruction. It returns enables that let a register writeback, a memory write or a branch take effect, or that suppress them.

Instructions are grouped, and a stop input closes the current group. The compare port's results are collected in a pending store while the group is open. They are merged into the visible file on the clock edge that ends the group. Until then, non-branch readers see the old values. A conditional branch is the single exception. It sees the newest value, whether that value came from an earlier compare in the same group or from a compare in the same cycle. Predicate 0 is hard-wired true, so it can serve as the guard for unconditional work and as a sink for an unused compare target.

Top module: `pred_guard_unit`

## Requirements
- R1: After reset, predicates 1 to 15 read false and predicate 0 reads true.
- R2: When the qualifying predicate is false, the issued instruction gets no enable at all: reg_we, mem_we and br_take all stay 0.
- R3: When the qualifying predicate is true, exactly the enable matching the class goes high. The class codes are iss_kind 0 for an ALU op and 1 for a load, both of which raise reg_we, 2 for a store, which raises mem_we, and 3 for a branch, which raises br_take.
- R4: Equality compare (cmp_kind 0): the first target gets cmp_a==cmp_b and the second target gets the inverse.
- R5: Inequality compare (cmp_kind 1): the first target gets cmp_a!=cmp_b and the second gets the inverse. Compared against zero, it gives a guard that replaces a branch around a block.
- R6: Bit test (cmp_kind 2): the first target gets bit cmp_b[4:0] of cmp_a and the second target gets its inverse.
- R7: A compare result is not visible to non-branch instructions before the cycle that follows a cycle with grp_stop high. A compare in that stop cycle itself belongs to the group that ends.
- R8: A branch (iss_kind 3) uses the newest value written in the open group, including a value written by a compare in the same cycle.
- R9: Predicate 0 always reads true, and any write aimed at it is discarded.
- R10: When both targets of one compare name the same predicate, the value meant for the first target is the one stored.
- R11: A compare whose own qualifying predicate cmp_qp is false writes neither target. cmp_qp is read from the visible file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | A compare is presented this cycle |
| cmp_kind | input | 2 | Compare kind: 0 equal, 1 not equal, 2 bit test |
| cmp_qp | input | 4 | Qualifying predicate of the compare |
| cmp_t1 | input | 4 | First target predicate (receives the result) |
| cmp_t2 | input | 4 | Second target predicate (receives the inverse) |
| cmp_a | input | 32 | First operand |
| cmp_b | input | 32 | Second operand; low 5 bits give the bit index for a bit test |
| grp_stop | input | 1 | Ends the current instruction group at this clock edge |
| iss_valid | input | 1 | An instruction is issued this cycle |
| iss_qp | input | 4 | Qualifying predicate of the issued instruction |
| iss_kind | input | 2 | Class: 0 ALU, 1 load, 2 store, 3 branch |
| reg_we | output | 1 | Register writeback allowed |
| mem_we | output | 1 | Memory write allowed |
| br_take | output | 1 | Conditional branch taken |

## Verification
A compare and an issued instruction can land in the same cycle and name the same predicate. A branch must then see the new value, while an ALU op, load or store must see the old one. The bench pairs a compare with a branch on its first target in one cycle, and with a non-branch reader on that same predicate in the next cycles. The stop comes later. A reference model in the bench keeps separate visible and pending states, and each enable is judged against the state that applies to its class.

// File: rtl/pgu_pkg.sv
// Shared encodings for the predicate register and guard unit.
// Assumes the top-level ports carry these codes as plain 2-bit vectors.
package pgu_pkg;

    typedef enum logic [1:0] {
        CMP_EQ   = 2'd0,
        CMP_NE   = 2'd1,
        CMP_TBIT = 2'd2,
        CMP_RSVD = 2'd3
    } cmp_kind_e;

    typedef enum logic [1:0] {
        ISS_ALU    = 2'd0,
        ISS_LOAD   = 2'd1,
        ISS_STORE  = 2'd2,
        ISS_BRANCH = 2'd3
    } iss_kind_e;

endpackage

// File: rtl/pgu_cmp_eval.sv
// Compare evaluator: computes the compare result and turns it into a
// per-predicate write mask and write value for the complementary pair.
// Assumes arch_vec is the visible predicate file with bit 0 tied true.
// Writes to predicate 0 are dropped; when both targets are equal, the
// first target's value is the one driven.
module pgu_cmp_eval #(
    parameter int NPRED  = 16,
    parameter int DATA_W = 32
) (
    input  logic                     cmp_valid,
    input  logic [1:0]               cmp_kind,
    input  logic [$clog2(NPRED)-1:0] cmp_qp,
    input  logic [$clog2(NPRED)-1:0] cmp_t1,
    input  logic [$clog2(NPRED)-1:0] cmp_t2,
    input  logic [DATA_W-1:0]        cmp_a,
    input  logic [DATA_W-1:0]        cmp_b,
    input  logic [NPRED-1:0]         arch_vec,
    output logic [NPRED-1:0]         wr_mask,
    output logic [NPRED-1:0]         wr_val
);
    import pgu_pkg::*;

    localparam int BIT_W = $clog2(DATA_W);

    logic               res;
    logic               fire;
    logic [BIT_W-1:0]   bit_idx;
    cmp_kind_e          kind;

    // Evaluate the selected compare and its guard.
    always_comb begin
        kind    = cmp_kind_e'(cmp_kind);
        bit_idx = cmp_b[BIT_W-1:0];
        fire    = cmp_valid & arch_vec[cmp_qp];
        unique case (kind)
            CMP_EQ:   res = (cmp_a == cmp_b);
            CMP_NE:   res = (cmp_a != cmp_b);
            CMP_TBIT: res = cmp_a[bit_idx];
            default:  res = 1'b0;
        endcase
    end

    // Per-predicate write decode; entry 0 is a sink.
    for (genvar i = 0; i < NPRED; i++) begin : g_dec
        if (i == 0) begin : g_sink
            assign wr_mask[i] = 1'b0;
            assign wr_val[i]  = 1'b0;
        end else begin : g_live
            logic hit1;
            logic hit2;
            assign hit1       = fire && (cmp_t1 == i[$clog2(NPRED)-1:0]);
            assign hit2       = fire && (cmp_t2 == i[$clog2(NPRED)-1:0]);
            assign wr_mask[i] = hit1 | hit2;
            assign wr_val[i]  = hit1 ? res : ~res;
        end
    end

endmodule

// File: rtl/pgu_pred_file.sv
// Predicate storage: a visible file plus a pending store for the open
// instruction group. Pending writes merge into the visible file on a clock
// edge where grp_stop is high. fwd_vec shows the newest value of each
// predicate, including writes from the current cycle, for branch readers.
// Assumes wr_mask[0] is always 0; bit 0 of both outputs is tied true.
module pgu_pred_file #(
    parameter int NPRED = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_stop,
    input  logic [NPRED-1:0] wr_mask,
    input  logic [NPRED-1:0] wr_val,
    output logic [NPRED-1:0] arch_vec,
    output logic [NPRED-1:0] fwd_vec
);
    logic [NPRED-1:1] arch_q;
    logic [NPRED-1:0] pend_m_q;
    logic [NPRED-1:0] pend_v_q;
    logic [NPRED-1:0] pend_m_n;
    logic [NPRED-1:0] pend_v_n;
    logic [NPRED-1:0] merged;

    // Fold this cycle's writes into the pending store; later writes win.
    always_comb begin
        pend_m_n = pend_m_q | wr_mask;
        pend_v_n = (pend_v_q & ~wr_mask) | (wr_val & wr_mask);
        arch_vec = {arch_q, 1'b1};
        merged   = (arch_vec & ~pend_m_n) | (pend_v_n & pend_m_n);
        fwd_vec  = merged;
    end

    // Commit pending writes at a group end, otherwise keep collecting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_q   <= '0;
            pend_m_q <= '0;
            pend_v_q <= '0;
        end else if (grp_stop) begin
            arch_q   <= merged[NPRED-1:1];
            pend_m_q <= '0;
            pend_v_q <= '0;
        end else begin
            pend_m_q <= pend_m_n;
            pend_v_q <= pend_v_n;
        end
    end

endmodule

// File: rtl/pgu_guard.sv
// Guard logic: looks up the qualifying predicate of the issued instruction
// and raises the enable for its class. Branches read the forwarded view,
// and all other classes read the visible file. Purely combinational.
module pgu_guard #(
    parameter int NPRED = 16
) (
    input  logic                     iss_valid,
    input  logic [$clog2(NPRED)-1:0] iss_qp,
    input  logic [1:0]               iss_kind,
    input  logic [NPRED-1:0]         arch_vec,
    input  logic [NPRED-1:0]         fwd_vec,
    output logic                     reg_we,
    output logic                     mem_we,
    output logic                     br_take
);
    import pgu_pkg::*;

    iss_kind_e kind;
    logic      qv;
    logic      go;

    // Select the predicate view by class and decode the enables.
    always_comb begin
        kind    = iss_kind_e'(iss_kind);
        qv      = (kind == ISS_BRANCH) ? fwd_vec[iss_qp] : arch_vec[iss_qp];
        go      = iss_valid & qv;
        reg_we  = 1'b0;
        mem_we  = 1'b0;
        br_take = 1'b0;
        unique case (kind)
            ISS_ALU, ISS_LOAD: reg_we  = go;
            ISS_STORE:         mem_we  = go;
            ISS_BRANCH:        br_take = go;
            default:           reg_we  = 1'b0;
        endcase
    end

endmodule

// File: rtl/pred_guard_unit.sv
// Top of the predicate register and guard unit. It connects the compare
// evaluator, the grouped predicate storage and the guard decode.
// Assumes one compare and one issued instruction at most per cycle.
module pred_guard_unit #(
    parameter int NPRED  = 16,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmp_valid,
    input  logic [1:0]               cmp_kind,
    input  logic [$clog2(NPRED)-1:0] cmp_qp,
    input  logic [$clog2(NPRED)-1:0] cmp_t1,
    input  logic [$clog2(NPRED)-1:0] cmp_t2,
    input  logic [DATA_W-1:0]        cmp_a,
    input  logic [DATA_W-1:0]        cmp_b,
    input  logic                     grp_stop,
    input  logic                     iss_valid,
    input  logic [$clog2(NPRED)-1:0] iss_qp,
    input  logic [1:0]               iss_kind,
    output logic                     reg_we,
    output logic                     mem_we,
    output logic                     br_take
);
    logic [NPRED-1:0] arch_vec;
    logic [NPRED-1:0] fwd_vec;
    logic [NPRED-1:0] wr_mask;
    logic [NPRED-1:0] wr_val;

    pgu_cmp_eval #(.NPRED(NPRED), .DATA_W(DATA_W)) u_cmp (
        .cmp_valid (cmp_valid),
        .cmp_kind  (cmp_kind),
        .cmp_qp    (cmp_qp),
        .cmp_t1    (cmp_t1),
        .cmp_t2    (cmp_t2),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .arch_vec  (arch_vec),
        .wr_mask   (wr_mask),
        .wr_val    (wr_val)
    );

    pgu_pred_file #(.NPRED(NPRED)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .grp_stop (grp_stop),
        .wr_mask  (wr_mask),
        .wr_val   (wr_val),
        .arch_vec (arch_vec),
        .fwd_vec  (fwd_vec)
    );

    pgu_guard #(.NPRED(NPRED)) u_guard (
        .iss_valid (iss_valid),
        .iss_qp    (iss_qp),
        .iss_kind  (iss_kind),
        .arch_vec  (arch_vec),
        .fwd_vec   (fwd_vec),
        .reg_we    (reg_we),
        .mem_we    (mem_we),
        .br_take   (br_take)
    );

endmodule

// File: rtl/pgu_chk.sv
// Assertion checker for pred_guard_unit, attached by bind below. It relates
// the guard outputs to the storage and compare-decode signals.
module pgu_chk #(
    parameter int NPRED = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmp_valid,
    input logic [$clog2(NPRED)-1:0] cmp_qp,
    input logic                     grp_stop,
    input logic                     iss_valid,
    input logic [$clog2(NPRED)-1:0] iss_qp,
    input logic [1:0]               iss_kind,
    input logic                     reg_we,
    input logic                     mem_we,
    input logic                     br_take,
    input logic [NPRED-1:0]         arch_vec,
    input logic [NPRED-1:0]         wr_mask,
    input logic [NPRED-1:0]         wr_val
);
    // R2
    qp_false_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_kind != 2'd3 && !arch_vec[iss_qp])
            |-> (!reg_we && !mem_we && !br_take));

    // R9
    p0_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_qp == '0) |-> (reg_we || mem_we || br_take));

    // R7
    hold_until_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_stop |=> $stable(arch_vec));

    // R8
    branch_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_kind == 2'd3 && wr_mask[iss_qp])
            |-> (br_take == wr_val[iss_qp]));

    // R11
    guarded_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !arch_vec[cmp_qp]) |-> (wr_mask == '0));

endmodule

bind pred_guard_unit pgu_chk #(.NPRED(NPRED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_qp    (cmp_qp),
    .grp_stop  (grp_stop),
    .iss_valid (iss_valid),
    .iss_qp    (iss_qp),
    .iss_kind  (iss_kind),
    .reg_we    (reg_we),
    .mem_we    (mem_we),
    .br_take   (br_take),
    .arch_vec  (arch_vec),
    .wr_mask   (wr_mask),
    .wr_val    (wr_val)
);

// File: tb/pred_guard_unit_bench.sv
// Scoreboard bench: the driver task computes expected enables from a
// reference model of the requirements and queues them; a monitor compares.
module pred_guard_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_kind = '0;
    logic [3:0]  cmp_qp = '0, cmp_t1 = '0, cmp_t2 = '0;
    logic [31:0] cmp_a = '0, cmp_b = '0;
    logic        grp_stop = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_qp = '0;
    logic [1:0]  iss_kind = '0;
    logic        reg_we, mem_we, br_take;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [2:0] q_exp[$];
    string      q_tag[$];

    logic [15:0] m_arch = 16'h0001;
    logic [15:0] m_pm   = '0;
    logic [15:0] m_pv   = '0;

    localparam logic [1:0] EQ = 2'd0, NE = 2'd1, TB = 2'd2;
    localparam logic [1:0] ALU = 2'd0, LD = 2'd1, ST = 2'd2, BR = 2'd3;

    always #10 clk = ~clk;

    pred_guard_unit u_pred_guard_unit (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
        .cmp_qp(cmp_qp), .cmp_t1(cmp_t1), .cmp_t2(cmp_t2), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .grp_stop(grp_stop), .iss_valid(iss_valid),
        .iss_qp(iss_qp), .iss_kind(iss_kind), .reg_we(reg_we),
        .mem_we(mem_we), .br_take(br_take)
    );

    // Driver: apply one cycle, queue expected enables, advance the model.
    task automatic tick(input logic cv, input logic [1:0] ck, input logic [3:0] cq,
                        input logic [3:0] t1, input logic [3:0] t2,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic stop, input logic [3:0] iq,
                        input logic [1:0] ik, input string tag);
        logic [15:0] wm, wv, pm_n, pv_n;
        logic r, qv, go;
        @(negedge clk);
        cmp_valid = cv; cmp_kind = ck; cmp_qp = cq; cmp_t1 = t1; cmp_t2 = t2;
        cmp_a = a; cmp_b = b; grp_stop = stop;
        iss_valid = 1'b1; iss_qp = iq; iss_kind = ik;
        case (ck)
            EQ:      r = (a == b);
            NE:      r = (a != b);
            TB:      r = a[b[4:0]];
            default: r = 1'b0;
        endcase
        wm = '0; wv = '0;
        if (cv && m_arch[cq]) begin
            if (t2 != 0) begin wm[t2] = 1'b1; wv[t2] = ~r; end
            if (t1 != 0) begin wm[t1] = 1'b1; wv[t1] = r; end
        end
        pm_n = m_pm | wm;
        pv_n = (m_pv & ~wm) | (wv & wm);
        if (ik == BR) qv = pm_n[iq] ? pv_n[iq] : m_arch[iq];
        else          qv = m_arch[iq];
        go = qv;
        q_exp.push_back({go && (ik == ALU || ik == LD), go && (ik == ST), go && (ik == BR)});
        q_tag.push_back(tag);
        if (stop) begin
            m_arch = (m_arch & ~pm_n) | (pv_n & pm_n);
            m_arch[0] = 1'b1;
            m_pm = '0; m_pv = '0;
        end else begin
            m_pm = pm_n; m_pv = pv_n;
        end
    endtask

    task automatic iss(input logic stop, input logic [3:0] iq, input logic [1:0] ik,
                       input string tag);
        tick(1'b0, EQ, 4'd0, 4'd0, 4'd0, 32'd0, 32'd0, stop, iq, ik, tag);
    endtask

    // Monitor: compare queued expectations mid-cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            #8;
            while (q_exp.size() > 0) begin
                logic [2:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                checks++;
                if ({reg_we, mem_we, br_take} !== e) begin
                    fails++;
                    $display("FAIL %s: reg/mem/br got %b expected %b", t,
                             {reg_we, mem_we, br_take}, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R9 predicate 0 true
        for (int k = 0; k < 16; k++) iss(1'b0, k[3:0], ALU, (k == 0) ? "R9" : "R1");
        // R4 equality pair, R7 hidden until stop
        tick(1'b1, EQ, 4'd0, 4'd1, 4'd2, 32'd5, 32'd5, 1'b0, 4'd1, ALU, "R7");
        iss(1'b1, 4'd1, ALU, "R7");
        iss(1'b0, 4'd1, ALU, "R4");
        iss(1'b0, 4'd2, ST, "R4");
        // R3 class decode
        iss(1'b0, 4'd1, ST, "R3");
        iss(1'b0, 4'd1, LD, "R3");
        iss(1'b0, 4'd1, BR, "R3");
        // R8 same-cycle and same-group branch forwarding
        tick(1'b1, NE, 4'd0, 4'd3, 4'd4, 32'd7, 32'd0, 1'b0, 4'd3, BR, "R8");
        iss(1'b0, 4'd4, BR, "R8");
        iss(1'b0, 4'd3, BR, "R8");
        iss(1'b0, 4'd3, ALU, "R7");
        iss(1'b1, 4'd3, LD, "R7");
        iss(1'b0, 4'd3, ALU, "R5");
        iss(1'b0, 4'd2, BR, "R2");
        // R6 bit test
        tick(1'b1, TB, 4'd0, 4'd5, 4'd6, 32'h20, 32'd5, 1'b1, 4'd0, ALU, "R9");
        iss(1'b0, 4'd5, ALU, "R6");
        iss(1'b0, 4'd6, ALU, "R6");
        tick(1'b1, TB, 4'd0, 4'd5, 4'd6, 32'h20, 32'd4, 1'b1, 4'd5, ALU, "R7");
        iss(1'b0, 4'd5, ALU, "R6");
        iss(1'b0, 4'd6, ST, "R6");
        // R9 write to predicate 0 discarded
        tick(1'b1, EQ, 4'd0, 4'd0, 4'd7, 32'd1, 32'd2, 1'b1, 4'd0, ALU, "R9");
        iss(1'b0, 4'd0, ALU, "R9");
        iss(1'b0, 4'd7, ALU, "R4");
        // R10 same target twice: first target value kept
        tick(1'b1, EQ, 4'd0, 4'd8, 4'd8, 32'd9, 32'd9, 1'b1, 4'd0, LD, "R10");
        iss(1'b0, 4'd8, ALU, "R10");
        tick(1'b1, EQ, 4'd0, 4'd8, 4'd8, 32'd1, 32'd2, 1'b1, 4'd0, LD, "R10");
        iss(1'b0, 4'd8, ALU, "R10");
        // R11 guarded compare with false guard (p5 is 0) writes nothing
        tick(1'b1, EQ, 4'd5, 4'd9, 4'd10, 32'd3, 32'd4, 1'b0, 4'd10, BR, "R11");
        iss(1'b1, 4'd10, ALU, "R11");
        iss(1'b0, 4'd10, ALU, "R11");
        tick(1'b1, EQ, 4'd6, 4'd9, 4'd10, 32'd3, 32'd4, 1'b1, 4'd0, ST, "R11");
        iss(1'b0, 4'd10, ALU, "R11");
        iss(1'b0, 4'd9, ALU, "R11");
        // R5 if-conversion against zero
        tick(1'b1, NE, 4'd0, 4'd11, 4'd12, 32'd0, 32'd0, 1'b1, 4'd11, ALU, "R5");
        iss(1'b0, 4'd11, ALU, "R5");
        iss(1'b0, 4'd12, LD, "R5");
        // R2 suppression across classes
        iss(1'b0, 4'd11, ST, "R2");
        iss(1'b0, 4'd11, BR, "R2");
        iss(1'b0, 4'd11, LD, "R2");
        @(negedge clk);
        iss_valid = 1'b0;
        cmp_valid = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule